// File: doc/BRIEF.md
# Fault injection loop tester

A hardware sequencer that drives a SECDED-protected memory controller through repeated self-test passes, with no processor involved. It acts as a master on two ports of the controller: a memory bus for word reads and writes, and a small register port that switches protection on and off, clears the error counters and reads them back. A run starts from a single command. The command selects single-bit or double-bit injection, a base test address and a data pattern.

In every iteration the sequencer writes the clean pattern while protection is on. It then turns protection off and writes a copy of the pattern with one or two bits inverted, so the stored check bits no longer match the data. It turns protection back on, reads the word and judges the result. Single-bit mode expects corrected data with no double-error flag. Double-bit mode expects the double-error flag. In both modes the matching error counter must have grown by exactly one. The inverted positions move with the iteration number, so a long enough run hits every data bit. The first failing iteration ends the run and keeps the iteration number and the address for inspection.

Top module: `fault_loop_tester`

## Requirements
- R1: On `start` while idle, the first transaction of the run is a register write to address 1, which clears the controller's error counters and status.
- R2: Each iteration issues exactly seven transactions in this order: register write to address 0 with bit 0 = 1 (protection on), memory write of the clean pattern, register write to address 0 with bit 0 = 0 (protection off), memory write of the corrupted word, register write to address 0 with bit 0 = 1, memory read, then a register read of address 2 (single-bit mode) or address 3 (double-bit mode). Each transaction holds its request, address, data and direction until its acknowledge.
- R3: In iteration i, the corrupted word is the pattern XOR a mask. The mask has bit (i mod DW) set, plus bit ((i+1) mod DW) in double-bit mode. A run of at least DW iterations therefore inverts every data bit at least once.
- R4: All memory transactions of a run use the test address. That address is `base_addr` in single-bit mode and `base_addr + DBL_OFFSET` (default 0x2000) in double-bit mode.
- R5: The read check passes in single-bit mode when the read data equals the pattern and `mem_dbl` is low, and in double-bit mode when `mem_dbl` is high.
- R6: The counter check passes when the register read returns i+1 in iteration i.
- R7: When all ITERS iterations pass, `done` pulses high for exactly one cycle, `fail` stays low and `iter_count` equals ITERS.
- R8: The first failed check ends the run with no further transactions. `done` pulses, `fail` goes high, `iter_count` holds the failing iteration's index and `fail_addr` holds the test address.
- R9: `busy` is high from the cycle after an accepted `start` until the cycle `done` pulses. A `start` while busy has no effect on mode, address, pattern or sequence.
- R10: After reset, `busy`, `done`, `fail`, `mem_req` and `reg_req` are low, and no request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| dbl_mode | input | 1 | 0 = single-bit injection, 1 = double-bit injection |
| base_addr | input | AW | Base test address |
| pattern | input | DW | Clean data word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Last run stopped on a failed check |
| iter_count | output | CW | Iterations passed (index of the failing one after a failure) |
| fail_addr | output | AW | Test address latched on failure |
| reg_req | output | 1 | Register port request |
| reg_we | output | 1 | Register write (1) or read (0) |
| reg_addr | output | RAW | Register address: 0 control, 1 clear, 2 single count, 3 double count |
| reg_wdata | output | DW | Register write data |
| reg_ack | input | 1 | Register transaction accepted |
| reg_rdata | input | DW | Register read data, valid with `reg_ack` |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory transaction accepted |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| mem_dbl | input | 1 | Double-error indication, valid with a read `mem_ack` |

## Verification
The bench builds the sequencer with a 16-bit data word, 16-bit addresses and ITERS = 20. A single run is then longer than the word width, so the rotating mask covers every bit position in both modes, and the wrap of the bit index falls inside each run. With runs this short, the bench can walk every transaction of every run against an arithmetic expectation. It also places a controller fault at the first iteration, at a middle one and at the last one. It injects each class of fault (no correction, missing double-error flag, missed count) and compares the stopping iteration and total transaction count with values computed from the fault's position.

// File: rtl/fault_loop_tester.sv
module fault_loop_tester #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int RAW = 2,
  parameter int ITERS = 200,
  parameter logic [AW-1:0] DBL_OFFSET = AW'(32'h2000)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           dbl_mode,
  input  logic [AW-1:0]  base_addr,
  input  logic [DW-1:0]  pattern,
  output logic           busy,
  output logic           done,
  output logic           fail,
  output logic [$clog2(ITERS+1)-1:0] iter_count,
  output logic [AW-1:0]  fail_addr,
  output logic           reg_req,
  output logic           reg_we,
  output logic [RAW-1:0] reg_addr,
  output logic [DW-1:0]  reg_wdata,
  input  logic           reg_ack,
  input  logic [DW-1:0]  reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_dbl
);
  localparam int CW = $clog2(ITERS + 1);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [RAW-1:0] A_CTRL = RAW'(0);
  localparam logic [RAW-1:0] A_CLR  = RAW'(1);
  localparam logic [RAW-1:0] A_CNT1 = RAW'(2);
  localparam logic [RAW-1:0] A_CNT2 = RAW'(3);

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_EN1, S_WCLN, S_DIS, S_WBAD, S_EN2, S_RD, S_CNT
  } st_t;

  st_t            st;
  logic           mode;
  logic [AW-1:0]  taddr;
  logic [DW-1:0]  pat;
  logic [CW-1:0]  iter;
  logic [BW-1:0]  bitp;
  logic [BW-1:0]  bitp2;
  logic [DW-1:0]  flip;
  logic           ack;
  logic           rd_ok;
  logic           cnt_ok;

  assign bitp2  = (bitp == BW'(DW - 1)) ? '0 : bitp + 1'b1;
  assign flip   = (DW'(1) << bitp) | (mode ? (DW'(1) << bitp2) : '0);

  assign reg_req   = st inside {S_CLR, S_EN1, S_DIS, S_EN2, S_CNT};
  assign reg_we    = st != S_CNT;
  assign reg_addr  = (st == S_CLR) ? A_CLR : (st == S_CNT) ? (mode ? A_CNT2 : A_CNT1) : A_CTRL;
  assign reg_wdata = DW'(st != S_DIS);

  assign mem_req   = st inside {S_WCLN, S_WBAD, S_RD};
  assign mem_we    = st != S_RD;
  assign mem_addr  = taddr;
  assign mem_wdata = (st == S_WBAD) ? (pat ^ flip) : pat;

  assign ack    = reg_req ? reg_ack : (mem_req & mem_ack);
  assign rd_ok  = mode ? mem_dbl : (mem_rdata == pat && !mem_dbl);
  assign cnt_ok = reg_rdata == DW'(iter) + DW'(1);

  assign busy       = st != S_IDLE;
  assign iter_count = iter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode      <= 1'b0;
      taddr     <= '0;
      pat       <= '0;
      iter      <= '0;
      bitp      <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          mode  <= dbl_mode;
          taddr <= base_addr + (dbl_mode ? DBL_OFFSET : '0);
          pat   <= pattern;
          iter  <= '0;
          bitp  <= '0;
          fail  <= 1'b0;
          st    <= S_CLR;
        end
      end else if (ack) begin
        case (st)
          S_CLR:  st <= S_EN1;
          S_EN1:  st <= S_WCLN;
          S_WCLN: st <= S_DIS;
          S_DIS:  st <= S_WBAD;
          S_WBAD: st <= S_EN2;
          S_EN2:  st <= S_RD;
          S_RD: begin
            if (rd_ok) st <= S_CNT;
            else begin
              st        <= S_IDLE;
              done      <= 1'b1;
              fail      <= 1'b1;
              fail_addr <= taddr;
            end
          end
          S_CNT: begin
            if (!cnt_ok) begin
              st        <= S_IDLE;
              done      <= 1'b1;
              fail      <= 1'b1;
              fail_addr <= taddr;
            end else begin
              iter <= iter + 1'b1;
              bitp <= bitp2;
              if (iter == CW'(ITERS - 1)) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else st <= S_EN1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fault_loop_tester_chk.sv
module fault_loop_tester_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          reg_req,
  input logic          reg_ack,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  assert_ports_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && reg_req));

  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !reg_req);

  assert_fail_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(fail));
endmodule

bind fault_loop_tester fault_loop_tester_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
  .reg_req(reg_req), .reg_ack(reg_ack), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/fault_loop_tester_tb_top.sv
module fault_loop_tester_tb_top;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int RAW = 2;
  localparam int ITERS = 20;
  localparam int CW = $clog2(ITERS + 1);
  localparam logic [AW-1:0] BASE = 16'h0100;

  logic clk = 0, rst_n = 0;
  logic start = 0, dbl_mode = 0;
  logic [AW-1:0] base_addr = '0;
  logic [DW-1:0] pattern = '0;
  logic busy, done, fail;
  logic [CW-1:0] iter_count;
  logic [AW-1:0] fail_addr;
  logic reg_req, reg_we, reg_ack;
  logic [RAW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic mem_req, mem_we, mem_ack, mem_dbl;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #5ns clk = ~clk;

  fault_loop_tester #(.DW(DW), .AW(AW), .RAW(RAW), .ITERS(ITERS), .DBL_OFFSET(16'h2000)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dbl_mode(dbl_mode), .base_addr(base_addr),
    .pattern(pattern), .busy(busy), .done(done), .fail(fail), .iter_count(iter_count),
    .fail_addr(fail_addr), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_dbl(mem_dbl));

  // behavioural SECDED controller model
  logic [DW-1:0] md [2];
  logic [DW-1:0] mc [2];
  logic en = 0;
  logic [DW-1:0] cnt1 = 0, cnt2 = 0;
  int riter = 0;
  int nocorr_at = -1, nodbl_at = -1, skip_at = -1;
  logic stall = 0;
  logic [1:0] cyc = 0;
  logic gnt;
  logic [DW-1:0] diff;
  int pc;
  int k;

  assign gnt = !stall || (cyc == 2'b11);
  assign reg_ack = reg_req & gnt;
  assign mem_ack = mem_req & gnt;
  assign k = int'(mem_addr[13]);
  assign diff = md[k] ^ mc[k];
  assign pc = $countones(diff);
  assign mem_rdata = (en && pc == 1 && riter != nocorr_at) ? mc[k] : md[k];
  assign mem_dbl = en && pc == 2 && riter != nodbl_at;
  assign reg_rdata = (reg_addr == 2'd2) ? cnt1 : (reg_addr == 2'd3) ? cnt2 : '0;

  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (reg_req && reg_ack && reg_we) begin
      if (reg_addr == 2'd0) en <= reg_wdata[0];
      if (reg_addr == 2'd1) begin cnt1 <= 0; cnt2 <= 0; riter <= 0; end
    end
    if (mem_req && mem_ack && mem_we) begin
      md[k] <= mem_wdata;
      if (en) mc[k] <= mem_wdata;
    end
    if (mem_req && mem_ack && !mem_we) begin
      riter <= riter + 1;
      if (en && riter != skip_at) begin
        if (pc == 1) cnt1 <= cnt1 + 1'b1;
        if (pc == 2) cnt2 <= cnt2 + 1'b1;
      end
    end
  end

  // transaction monitor
  int tx_n = 0, clr_err = 0, ord_err = 0, flip_err = 0, addr_err = 0;
  logic exp_mode = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_pat = '0, cov = '0;

  function automatic logic [DW-1:0] exp_flip(int i, logic m);
    exp_flip = (DW'(1) << (i % DW)) | (m ? (DW'(1) << ((i + 1) % DW)) : '0);
  endfunction

  always @(posedge clk) begin
    if (rst_n && ((reg_req && reg_ack) || (mem_req && mem_ack))) begin
      if (tx_n == 0) begin
        if (!(reg_req && reg_we && reg_addr == 2'd1)) clr_err++;
      end else begin
        int i, s;
        i = (tx_n - 1) / 7;
        s = (tx_n - 1) % 7;
        case (s)
          0, 4: if (!(reg_req && reg_we && reg_addr == 2'd0 && reg_wdata[0])) ord_err++;
          2:    if (!(reg_req && reg_we && reg_addr == 2'd0 && !reg_wdata[0])) ord_err++;
          1: begin
            if (!(mem_req && mem_we && mem_wdata == exp_pat)) ord_err++;
            if (mem_addr != exp_addr) addr_err++;
          end
          3: begin
            if (!(mem_req && mem_we)) ord_err++;
            if (mem_wdata != (exp_pat ^ exp_flip(i, exp_mode))) flip_err++;
            cov = cov | (mem_wdata ^ exp_pat);
            if (mem_addr != exp_addr) addr_err++;
          end
          5: begin
            if (!(mem_req && !mem_we)) ord_err++;
            if (mem_addr != exp_addr) addr_err++;
          end
          default: if (!(reg_req && !reg_we && reg_addr == (exp_mode ? 2'd3 : 2'd2))) ord_err++;
        endcase
      end
      tx_n++;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic m, input logic [DW-1:0] p, input logic st, input int nc, input int nd,
                     input int sk, input int fail_it, input int exp_tx, input bit poke);
    int t;
    nocorr_at = nc; nodbl_at = nd; skip_at = sk; stall = st;
    @(negedge clk);
    tx_n = 0; clr_err = 0; ord_err = 0; flip_err = 0; addr_err = 0; cov = '0;
    exp_mode = m; exp_pat = p; exp_addr = BASE + (m ? 16'h2000 : 16'h0000);
    start = 1; dbl_mode = m; base_addr = BASE; pattern = p;
    @(negedge clk);
    start = 0; dbl_mode = ~m; pattern = ~p; base_addr = 16'h0444;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R7", "watchdog done", t, 0);
    chk(busy == 1'b0, "R9", "busy at done", busy, 0);
    chk(clr_err == 0, "R1", "clear first", clr_err, 0);
    chk(ord_err == 0, "R2", "order errors", ord_err, 0);
    chk(flip_err == 0, "R3", "mask errors", flip_err, 0);
    chk(addr_err == 0, "R4", "address errors", addr_err, 0);
    chk(tx_n == exp_tx, "R8", "transaction count", tx_n, exp_tx);
    if (fail_it < 0) begin
      chk(fail == 1'b0, "R7", "fail flag", fail, 0);
      chk(iter_count == CW'(ITERS), "R7", "iter count", iter_count, ITERS);
      chk(cov == '1, "R3", "bit coverage", cov, 16'hffff);
    end else begin
      chk(fail == 1'b1, "R8", "fail flag", fail, 1);
      chk(iter_count == CW'(fail_it), "R8", "fail iteration", iter_count, fail_it);
      chk(fail_addr == exp_addr, "R8", "fail address", fail_addr, exp_addr);
    end
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(!mem_req && !reg_req, "R10", "idle quiet", {mem_req, reg_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mem_req && !reg_req, "R10", "reset state",
        {busy, done, fail, mem_req, reg_req}, 0);
    rst_n = 1;
    @(negedge clk);
    // passing runs
    run(1'b0, 16'hA55A, 1'b0, -1, -1, -1, -1, 1 + 7 * ITERS, 0); // R5 R6 R7
    run(1'b1, 16'hFFFF, 1'b1, -1, -1, -1, -1, 1 + 7 * ITERS, 0);
    run(1'b0, 16'h0000, 1'b1, -1, -1, -1, -1, 1 + 7 * ITERS, 1); // R9 start ignored
    // failing runs: fault in read check stops after 6 tx of iteration, count fault after 7
    run(1'b0, 16'h0F0F, 1'b1, 5, -1, -1, 5, 1 + 7 * 5 + 6, 0);   // R5 single, no correction
    run(1'b1, 16'h1234, 1'b0, -1, 7, -1, 7, 1 + 7 * 7 + 6, 0);   // R5 double, no flag
    run(1'b0, 16'h8001, 1'b0, -1, -1, 3, 3, 1 + 7 * 3 + 7, 0);   // R6 missed count
    run(1'b1, 16'h7FFE, 1'b1, -1, -1, 0, 0, 8, 0);               // R6 first iteration
    run(1'b1, 16'h00FF, 1'b0, -1, ITERS - 1, -1, ITERS - 1, 1 + 7 * (ITERS - 1) + 6, 0); // R8 last
    run(1'b0, 16'h3C3C, 1'b0, -1, -1, -1, -1, 1 + 7 * ITERS, 0); // recovers after failure
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(10ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL R7 global watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule